// File: doc/BRIEF.md
# Real-Time Clock Host Register File

This block is the part of a real-time clock that the host sees. The host uses an indirect scheme. A write to port 0 picks a register index. An access to port 1 then writes or reads the register at that index. The block holds these registers:

- the rate/divider control register (A), whose top bit shows the update-busy input;
- the mode and interrupt-enable register (B);
- the event status register (C);
- the validity register (D);
- three alarm bytes.

It takes single-cycle pulses for the periodic, alarm and update-ended events and turns them into sticky flags. It also drives a level interrupt request.

The time counters, the rate generator and the alarm comparison are outside the block. They get the control and alarm contents through the `ctla_o`, `ctlb_o` and `alarm_o` outputs, and they send back the event pulses and the busy bit.

Every host access is a one-cycle request on `host_vld`. There is no back-pressure, so each request is taken in the cycle it is presented. Every read request, on either port, gives exactly one `rsp_vld` pulse one cycle later. That response carries the register value as it was in the request cycle.

The rest of the control state and the alarm bytes have no reset. They keep their contents across `rst_n`, in the way a battery-backed part would.

Top module: `rtc_regfile`

## Requirements
- R1: A port-0 write (`host_port`=0) keeps only bits 6..0 of the byte as the register index. Bit 7 is dropped, so writing 0x8B selects index 0x0B.
- R2: A port-1 write stores the byte in the selected register. Index 0x0B is mode/enable (B), 0x0A is control (A), and 0x01, 0x03 and 0x05 are alarm bytes 0, 1 and 2. Each read request gives `rsp_vld` high for exactly the next cycle, with the register value in `rsp_data`. `ctlb_o`, `ctla_o` and `alarm_o` (byte k at bits 8k+7..8k) follow the stored contents.
- R3: Bit 7 of register A reads as the `upd_busy` input from the request cycle. A host write to that bit has no effect.
- R4: Host writes to the status register (0x0C) and to the validity register (0x0D) are ignored.
- R5: Each event pulse always sets its flag in the status register: update-ended sets bit 4, alarm sets bit 5, periodic sets bit 6. Flags stay set until the register is read.
- R6: Status bit 7 and the `irq` output go high when one of these pairs is true: bit 4 with enable B bit 4, bit 5 with enable B bit 5, or bit 6 with enable B bit 6. If no such pair is true, they stay low.
- R7: A read of the status register returns its contents from before the read. It then clears the whole register, and `irq` falls in the same cycle that the response appears.
- R8: An event that arrives in the same cycle as a status read sets its flag, and its interrupt if enabled, after the clear. The event is not lost.
- R9: Reset clears B bits 6..3 and keeps B bits 7, 2, 1 and 0. It clears the status register, sets the validity register to 0x80 and sets the index to 0. Register A and the alarm bytes keep their values.
- R10: An index that holds no register reads as 0x00 and ignores writes. A port-0 read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_vld | input | 1 | Host request valid; always accepted |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_port | input | 1 | 0 = index port, 1 = data port |
| host_wdata | input | 8 | Write byte |
| rsp_vld | output | 1 | Read response valid, one cycle after the request |
| rsp_data | output | 8 | Read response byte |
| upd_busy | input | 1 | Update in progress, from the time counter |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_update | input | 1 | Update-ended pulse |
| irq | output | 1 | Level interrupt request |
| ctla_o | output | 7 | Rate and divider bits of register A |
| ctlb_o | output | 8 | Register B contents |
| alarm_o | output | 24 | Three alarm bytes, byte 0 lowest |

## Verification
A corrupted index shows up on the next data-port read, and it shows up as the wrong register. For example, a B value is returned where status was expected, or a read of status fails to clear it. A flag unit that loses a flag or keeps a stale one shows up at `irq` within one cycle of the event. It also shows up in the status byte on the next read. The case where a clear and a new event land in the same cycle is exercised on purpose, because a wrong priority there hides itself until the following read. Reset retention is checked by reading B, A and the alarms after a mid-run reset. The bits that are kept and the bits that are cleared differ by value.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;
  localparam int IDX_W = 7;
  localparam int DW    = 8;
  localparam int NUM_ALM = 3;

  localparam logic [IDX_W-1:0] IX_CTLA  = 7'h0A;
  localparam logic [IDX_W-1:0] IX_CTLB  = 7'h0B;
  localparam logic [IDX_W-1:0] IX_STAT  = 7'h0C;
  localparam logic [IDX_W-1:0] IX_VALID = 7'h0D;

  // Alarm k lives at index 2k+1
  function automatic logic [IDX_W-1:0] alm_index(int k);
    return IDX_W'(2 * k + 1);
  endfunction

  // Status bit positions
  localparam int ST_UPD = 4;
  localparam int ST_ALM = 5;
  localparam int ST_PER = 6;
  localparam int ST_IRQ = 7;

  localparam logic [DW-1:0] VALID_RESET = 8'h80;

  typedef struct packed {
    logic hold;
    logic per_en;
    logic alm_en;
    logic upd_en;
    logic sqw_en;
    logic bin_fmt;
    logic hr24;
    logic dst_en;
  } mode_t;
endpackage

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_vld,
  input  logic             host_wr,
  input  logic             host_port,
  input  logic [DW-1:0]    host_wdata,
  input  logic [DW-1:0]    rd_value,
  output logic [IDX_W-1:0] idx_o,
  output logic             reg_we,
  output logic             reg_re,
  output logic             rsp_vld,
  output logic [DW-1:0]    rsp_data
);
  logic [IDX_W-1:0] idx_q;
  logic             idx_we;
  logic             unused_hi;

  assign unused_hi = ^host_wdata[DW-1:IDX_W];
  assign idx_we    = host_vld && host_wr && !host_port;
  assign reg_we    = host_vld && host_wr && host_port;
  assign reg_re    = host_vld && !host_wr && host_port;
  assign idx_o     = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_we) begin
      idx_q <= host_wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_data <= '0;
    end else begin
      rsp_vld  <= host_vld && !host_wr;
      if (host_vld && !host_wr) begin
        rsp_data <= host_port ? rd_value : '0;
      end
    end
  end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      idx,
  input  logic                  reg_we,
  input  logic [DW-1:0]         wdata,
  input  logic                  upd_busy,
  output logic [DW-2:0]         ctla_o,
  output mode_t                 mode_o,
  output logic [NUM_ALM*DW-1:0] alarm_o,
  output logic                  hit_o,
  output logic [DW-1:0]         rdata_o
);
  logic [DW-2:0]       ctla_q;
  logic                hold_q, bin_q, hr24_q, dst_q;
  logic                per_en_q, alm_en_q, upd_en_q, sqw_en_q;
  logic                unused_a7;
  logic [NUM_ALM-1:0]  alm_sel;
  logic [DW-1:0]       alm_rd;

  assign unused_a7 = wdata[DW-1];

  // Register A: rate/divider bits, kept across reset
  always_ff @(posedge clk) begin
    if (reg_we && idx == IX_CTLA) ctla_q <= wdata[DW-2:0];
  end

  // Register B, retained part
  always_ff @(posedge clk) begin
    if (reg_we && idx == IX_CTLB) begin
      hold_q <= wdata[7];
      bin_q  <= wdata[2];
      hr24_q <= wdata[1];
      dst_q  <= wdata[0];
    end
  end

  // Register B, part cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_en_q <= 1'b0;
      alm_en_q <= 1'b0;
      upd_en_q <= 1'b0;
      sqw_en_q <= 1'b0;
    end else if (reg_we && idx == IX_CTLB) begin
      per_en_q <= wdata[6];
      alm_en_q <= wdata[5];
      upd_en_q <= wdata[4];
      sqw_en_q <= wdata[3];
    end
  end

  // Alarm bytes
  for (genvar k = 0; k < NUM_ALM; k++) begin : g_alm
    logic [DW-1:0] alm_q;
    assign alm_sel[k] = (idx == alm_index(k));
    always_ff @(posedge clk) begin
      if (reg_we && alm_sel[k]) alm_q <= wdata;
    end
    assign alarm_o[k*DW +: DW] = alm_q;
  end

  always_comb begin
    alm_rd = '0;
    for (int k = 0; k < NUM_ALM; k++) begin
      if (alm_sel[k]) alm_rd = alarm_o[k*DW +: DW];
    end
  end

  assign ctla_o = ctla_q;
  assign mode_o = '{hold: hold_q, per_en: per_en_q, alm_en: alm_en_q,
                    upd_en: upd_en_q, sqw_en: sqw_en_q, bin_fmt: bin_q,
                    hr24: hr24_q, dst_en: dst_q};

  always_comb begin
    hit_o   = 1'b1;
    rdata_o = '0;
    if (idx == IX_CTLA)     rdata_o = {upd_busy, ctla_q};
    else if (idx == IX_CTLB) rdata_o = mode_o;
    else if (|alm_sel)       rdata_o = alm_rd;
    else                     hit_o   = 1'b0;
  end
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
  import rtc_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_periodic,
  input  logic          evt_alarm,
  input  logic          evt_update,
  input  logic          per_en,
  input  logic          alm_en,
  input  logic          upd_en,
  input  logic          clr,
  output logic [DW-1:0] stat_o,
  output logic          irq_o
);
  logic [2:0] flg_q, flg_base, flg_n;
  logic       irq_q, irq_n;
  logic [2:0] en;

  assign en       = {per_en, alm_en, upd_en};
  // Clear first, then merge the events of the same cycle
  assign flg_base = clr ? 3'b000 : flg_q;
  assign flg_n    = flg_base | {evt_periodic, evt_alarm, evt_update};
  assign irq_n    = (!clr && irq_q) || |(flg_n & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      irq_q <= 1'b0;
    end else begin
      flg_q <= flg_n;
      irq_q <= irq_n;
    end
  end

  always_comb begin
    stat_o         = '0;
    stat_o[ST_UPD] = flg_q[0];
    stat_o[ST_ALM] = flg_q[1];
    stat_o[ST_PER] = flg_q[2];
    stat_o[ST_IRQ] = irq_q;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_vld,
  input  logic                  host_wr,
  input  logic                  host_port,
  input  logic [DW-1:0]         host_wdata,
  output logic                  rsp_vld,
  output logic [DW-1:0]         rsp_data,
  input  logic                  upd_busy,
  input  logic                  evt_periodic,
  input  logic                  evt_alarm,
  input  logic                  evt_update,
  output logic                  irq,
  output logic [DW-2:0]         ctla_o,
  output logic [DW-1:0]         ctlb_o,
  output logic [NUM_ALM*DW-1:0] alarm_o
);
  logic [IDX_W-1:0] sel_idx;
  logic             reg_we, reg_re, stat_clr;
  logic [DW-1:0]    rd_value, ctrl_rdata, stat_byte, valid_q;
  logic             ctrl_hit;
  mode_t            mode;

  rtc_host_port u_port (
    .clk(clk), .rst_n(rst_n), .host_vld(host_vld), .host_wr(host_wr),
    .host_port(host_port), .host_wdata(host_wdata), .rd_value(rd_value),
    .idx_o(sel_idx), .reg_we(reg_we), .reg_re(reg_re),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data)
  );

  rtc_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .idx(sel_idx), .reg_we(reg_we),
    .wdata(host_wdata), .upd_busy(upd_busy), .ctla_o(ctla_o),
    .mode_o(mode), .alarm_o(alarm_o), .hit_o(ctrl_hit), .rdata_o(ctrl_rdata)
  );

  assign stat_clr = reg_re && (sel_idx == IX_STAT);

  rtc_flag_unit u_flags (
    .clk(clk), .rst_n(rst_n), .evt_periodic(evt_periodic),
    .evt_alarm(evt_alarm), .evt_update(evt_update),
    .per_en(mode.per_en), .alm_en(mode.alm_en), .upd_en(mode.upd_en),
    .clr(stat_clr), .stat_o(stat_byte), .irq_o(irq)
  );

  // Validity register: loaded by reset, never written by the host
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= VALID_RESET;
    else        valid_q <= valid_q;
  end

  always_comb begin
    if (ctrl_hit)                  rd_value = ctrl_rdata;
    else if (sel_idx == IX_STAT)   rd_value = stat_byte;
    else if (sel_idx == IX_VALID)  rd_value = valid_q;
    else                           rd_value = '0;
  end

  assign ctlb_o = mode;
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
  import rtc_regs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             host_vld,
  input logic             host_wr,
  input logic             host_port,
  input logic [IDX_W-1:0] idx,
  input logic             upd_busy,
  input logic             evt_periodic,
  input logic             evt_alarm,
  input logic             evt_update,
  input logic [DW-1:0]    ctlb,
  input logic [DW-1:0]    stat,
  input logic             rsp_vld,
  input logic [DW-1:0]    rsp_data,
  input logic             irq
);
  logic rd_req, rd_stat, rd_ctla, no_evt;
  assign rd_req  = host_vld && !host_wr;
  assign rd_stat = rd_req && host_port && idx == IX_STAT;
  assign rd_ctla = rd_req && host_port && idx == IX_CTLA;
  assign no_evt  = !evt_periodic && !evt_alarm && !evt_update;

  assert_rsp_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_vld);
  assert_rsp_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_vld);
  assert_busy_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctla |=> rsp_data[7] == $past(upd_busy));
  assert_flag_upd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_update |=> stat[ST_UPD]);
  assert_flag_alm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_alarm |=> stat[ST_ALM]);
  assert_flag_per_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_periodic |=> stat[ST_PER]);
  assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_periodic && ctlb[6]) || (evt_alarm && ctlb[5]) || (evt_update && ctlb[4])) |=> irq);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && no_evt) |=> (stat == '0 && !irq));
  assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && evt_update) |=> stat[ST_UPD]);
  assert_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (stat == '0 && !irq && idx == '0));
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_vld(host_vld), .host_wr(host_wr),
  .host_port(host_port), .idx(sel_idx), .upd_busy(upd_busy),
  .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
  .ctlb(ctlb_o), .stat(stat_byte), .rsp_vld(rsp_vld), .rsp_data(rsp_data),
  .irq(irq)
);

// File: tb/test_rtc_regfile.sv
`timescale 1ns/1ps
module test_rtc_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_vld = 1'b0, host_wr = 1'b0, host_port = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic        rsp_vld;
  logic [7:0]  rsp_data;
  logic        upd_busy = 1'b0;
  logic        evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0;
  logic        irq;
  logic [6:0]  ctla_o;
  logic [7:0]  ctlb_o;
  logic [23:0] alarm_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_regfile i_rtc_regfile (
    .clk(clk), .rst_n(rst_n), .host_vld(host_vld), .host_wr(host_wr),
    .host_port(host_port), .host_wdata(host_wdata), .rsp_vld(rsp_vld),
    .rsp_data(rsp_data), .upd_busy(upd_busy), .evt_periodic(evt_periodic),
    .evt_alarm(evt_alarm), .evt_update(evt_update), .irq(irq),
    .ctla_o(ctla_o), .ctlb_o(ctlb_o), .alarm_o(alarm_o)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic port, logic [7:0] d);
    @(negedge clk);
    host_vld = 1'b1; host_wr = 1'b1; host_port = port; host_wdata = d;
    @(negedge clk);
    host_vld = 1'b0; host_wr = 1'b0;
  endtask

  task automatic rd(logic port, output logic [7:0] d);
    @(negedge clk);
    host_vld = 1'b1; host_wr = 1'b0; host_port = port;
    @(negedge clk);
    host_vld = 1'b0;
    if (!rsp_vld) begin
      n_chk++; n_fail++;
      $display("FAIL R2: rsp_vld got 0 expected 1");
    end
    d = rsp_data;
  endtask

  task automatic rd_reg(logic [7:0] ix, output logic [7:0] d);
    wr(1'b0, ix);
    rd(1'b1, d);
  endtask

  task automatic wr_reg(logic [7:0] ix, logic [7:0] v);
    wr(1'b0, ix);
    wr(1'b1, v);
  endtask

  task automatic pulse(logic p, logic a, logic u);
    @(negedge clk);
    evt_periodic = p; evt_alarm = a; evt_update = u;
    @(negedge clk);
    evt_periodic = 1'b0; evt_alarm = 1'b0; evt_update = 1'b0;
  endtask

  task automatic t_reset_state;
    logic [7:0] d;
    check("R9 irq after reset", irq, 0);
    rd(1'b1, d); check("R9/R10 index 0 reads 0", d, 8'h00);
    rd(1'b0, d); check("R10 port0 read", d, 8'h00);
    rd_reg(8'h0C, d); check("R9 status cleared", d, 8'h00);
    rd_reg(8'h0D, d); check("R9 validity", d, 8'h80);
  endtask

  task automatic t_index_and_mode;
    logic [7:0] d;
    wr(1'b0, 8'h8B);
    wr(1'b1, 8'h07);
    rd(1'b1, d); check("R1 bit7 of index dropped", d, 8'h07);
    check("R2 ctlb_o", ctlb_o, 8'h07);
  endtask

  task automatic t_ctla;
    logic [7:0] d;
    upd_busy = 1'b1;
    wr_reg(8'h0A, 8'h26);
    wr(1'b1, 8'h26);
    wr(1'b1, 8'hA6);
    rd(1'b1, d); check("R3 busy bit reads input", d, 8'hA6);
    upd_busy = 1'b0;
    rd(1'b1, d); check("R3 host bit7 write ignored", d, 8'h26);
    check("R2 ctla_o", ctla_o, 7'h26);
  endtask

  task automatic t_alarms;
    logic [7:0] d;
    wr_reg(8'h01, 8'h30);
    wr_reg(8'h03, 8'h15);
    wr_reg(8'h05, 8'hC0);
    rd_reg(8'h03, d); check("R2 alarm 1 readback", d, 8'h15);
    check("R2 alarm_o", alarm_o, 24'hC01530);
  endtask

  task automatic t_read_only;
    logic [7:0] d;
    wr_reg(8'h0C, 8'hF0);
    check("R4 status write no irq", irq, 0);
    rd(1'b1, d); check("R4 status write ignored", d, 8'h00);
    wr_reg(8'h0D, 8'h00);
    rd(1'b1, d); check("R4 validity write ignored", d, 8'h80);
    wr_reg(8'h20, 8'h55);
    rd(1'b1, d); check("R10 unmapped index", d, 8'h00);
  endtask

  task automatic t_flag_no_enable;
    logic [7:0] d;
    wr_reg(8'h0B, 8'h00);
    wr(1'b0, 8'h0C);
    pulse(1'b1, 1'b0, 1'b0);
    check("R6 no irq without enable", irq, 0);
    rd(1'b1, d); check("R5 periodic flag", d, 8'h40);
    rd(1'b1, d); check("R7 cleared after read", d, 8'h00);
  endtask

  task automatic t_irq_paths;
    logic [7:0] d;
    wr_reg(8'h0B, 8'h40);
    wr(1'b0, 8'h0C);
    pulse(1'b1, 1'b0, 1'b0);
    check("R6 irq on periodic", irq, 1);
    rd(1'b1, d); check("R7 pre-clear value", d, 8'hC0);
    check("R7 irq falls", irq, 0);
    wr_reg(8'h0B, 8'h30);
    wr(1'b0, 8'h0C);
    pulse(1'b0, 1'b0, 1'b1);
    check("R6 irq on update", irq, 1);
    rd(1'b1, d); check("R5 update flag", d, 8'h90);
    wr_reg(8'h0B, 8'h10);
    wr(1'b0, 8'h0C);
    pulse(1'b0, 1'b1, 1'b0);
    check("R6 alarm without enable", irq, 0);
    rd(1'b1, d); check("R5 alarm flag", d, 8'h20);
  endtask

  task automatic t_coincide;
    logic [7:0] d;
    wr_reg(8'h0B, 8'h10);
    wr(1'b0, 8'h0C);
    pulse(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    host_vld = 1'b1; host_wr = 1'b0; host_port = 1'b1; evt_update = 1'b1;
    @(negedge clk);
    host_vld = 1'b0; evt_update = 1'b0;
    check("R8 read returns old", rsp_data, 8'h90);
    check("R8 irq stays", irq, 1);
    rd(1'b1, d); check("R8 new event kept", d, 8'h90);
  endtask

  task automatic t_reset_retain;
    logic [7:0] d;
    wr_reg(8'h0A, 8'h2F);
    wr_reg(8'h01, 8'h11);
    wr_reg(8'h0B, 8'hFF);
    pulse(1'b1, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R9 irq cleared", irq, 0);
    check("R9 ctlb_o", ctlb_o, 8'h87);
    rd(1'b1, d); check("R9 index reset to 0", d, 8'h00);
    rd_reg(8'h0B, d); check("R9 mode retained", d, 8'h87);
    rd_reg(8'h0A, d); check("R9 ctla retained", d, 8'h2F);
    rd_reg(8'h01, d); check("R9 alarm retained", d, 8'h11);
    rd_reg(8'h0C, d); check("R9 status cleared", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_index_and_mode();
    t_ctla();
    t_alarms();
    t_read_only();
    t_flag_no_enable();
    t_irq_paths();
    t_coincide();
    t_reset_retain();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule